// File: doc/BRIEF.md
# Byte-Bus 16-Bit Timer Register Bridge

This block puts a 16-bit up-counter and a 16-bit compare register behind a peripheral bus that is only one byte wide. It has one shared temporary byte latch. In 16-bit mode, software writes the high byte first. That byte is parked in the latch, and the following low-byte write commits both halves to the target register on the same clock edge. A read of the counter's high byte freezes the counter's low byte in the latch, so the later low-byte read returns a value consistent with the high byte. In 8-bit mode the latch is bypassed and each half is read or written directly, in any order.

A clock-stop register holds a run/standby bit. In standby the counter is frozen and writes to the timer registers and the status register are dropped, while reads still return the held contents. A sticky match flag is raised when the counter equals the compare value. Software clears the flag by writing a zero to it.

The bus is a single-cycle access port with no back-pressure. Every cycle with `acc_en` high is one complete access and is accepted at once. Read data is combinational in that same cycle. The counter advances on `cnt_tick`, which is a plain control input.

Top module: `tmr16_byte_bridge`

## Requirements
- R1: After reset the counter is 0x0000, the compare register is 0xFFFF, the match flag is 0, and the clock-stop register reads 0xFF, so the timer is running.
- R2: In 16-bit mode (`mode16`=1), a high-byte write (address 0 = counter high, address 2 = compare high) stores the byte in the temporary latch only. The target register keeps its value.
- R3: In 16-bit mode, a low-byte write (address 1 = counter low, address 3 = compare low) loads {latch, bus byte} into the whole target register on one edge.
- R4: In 16-bit mode, reading address 0 returns the live counter high byte and copies the live counter low byte into the latch. Reading address 1 then returns the latch. Compare reads return the register bytes directly in both modes.
- R5: The latch is shared between the two registers. A 16-bit high write to one register followed by a 16-bit low write to the other commits the latch content into the second register and leaves the first register unchanged.
- R6: In 8-bit mode, a write to address 0/1/2/3 replaces only that byte. Reads return live bytes. The latch is neither used nor changed, and the order of access is free.
- R7: While running, the counter increases by one on every clock edge with `cnt_tick`=1. An accepted counter write on the same edge wins, and no increment happens on that edge.
- R8: Clock-stop register at address 5, bit 2: 1 means run, 0 means standby. In standby the counter is frozen and writes to addresses 0–4 are ignored. Reads keep working. Address 5 is always writable.
- R9: While running, if the counter equals the compare value at a clock edge, the match flag (`match_flag`, and status bit 0 at address 4) is 1 from that edge on. It is sticky.
- R10: Writing address 4 with bit 0 = 0 clears the flag, and writing bit 0 = 1 has no effect. If a match is present on the same edge as a clear, the set wins.
- R11: Addresses 6 and 7 read 0x00. `acc_rdata` is 0x00 whenever no read is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode16 | input | 1 | 1 = 16-bit latched access, 0 = 8-bit direct access |
| acc_en | input | 1 | Access strobe, one access per cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 3 | Register address |
| acc_wdata | input | 8 | Write byte |
| acc_rdata | output | 8 | Read byte, valid in the access cycle |
| cnt_tick | input | 1 | Counter advance enable |
| match_flag | output | 1 | Sticky compare-match flag |

## Verification
The bench builds the block with its default parameters: byte width 8 and run bit at position 2. With these defaults, every byte value and every latch interaction can be driven through a handful of bus cycles. The vector table covers the latch hazards: a high write with no low write, a read-capture followed by an 8-bit overwrite, and a high/low crossover between the two registers. The directed tests cover the counter's timing: match latency, a write beating an increment, a clear racing a set, and standby freezing.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int AW = 3;
  localparam logic [AW-1:0] A_CNT_HI = 3'd0;
  localparam logic [AW-1:0] A_CNT_LO = 3'd1;
  localparam logic [AW-1:0] A_CMP_HI = 3'd2;
  localparam logic [AW-1:0] A_CMP_LO = 3'd3;
  localparam logic [AW-1:0] A_STAT   = 3'd4;
  localparam logic [AW-1:0] A_CKSTP  = 3'd5;
  typedef logic [1:0] bmask_t;
endpackage

// File: rtl/tmr16_bytereg.sv
module tmr16_bytereg #(
  parameter int DW = 8,
  parameter int NB = 2,
  parameter logic [NB*DW-1:0] INIT = '0,
  parameter bit HAS_INC = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NB-1:0]   we,
  input  logic [NB*DW-1:0] wval,
  input  logic            inc_en,
  output logic [NB*DW-1:0] q
);
  localparam int W = NB * DW;

  logic [W-1:0]  nxt_inc;
  logic [DW-1:0] b_q [NB];
  logic          any_we;

  assign any_we = |we;

  if (HAS_INC) begin : g_inc
    assign nxt_inc = q + W'(1);
  end else begin : g_hold
    assign nxt_inc = q;
  end

  for (genvar g = 0; g < NB; g++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                b_q[g] <= INIT[g*DW +: DW];
      else if (we[g])            b_q[g] <= wval[g*DW +: DW];
      else if (!any_we && inc_en) b_q[g] <= nxt_inc[g*DW +: DW];
    end
    assign q[g*DW +: DW] = b_q[g];
  end
endmodule

// File: rtl/tmr16_match_flag.sv
module tmr16_match_flag #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] cnt_q,
  input  logic [CW-1:0] cmp_q,
  input  logic          clr,
  output logic          flag_q
);
  logic hit;
  assign hit = run && (cnt_q == cmp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= hit | (flag_q & ~clr);
  end
endmodule

// File: rtl/tmr16_bus_port.sv
module tmr16_bus_port
  import tmr16_pkg::*;
#(
  parameter int DW = 8,
  parameter int STBY_BIT = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode16,
  input  logic            acc_en,
  input  logic            acc_wr,
  input  logic [AW-1:0]   acc_addr,
  input  logic [DW-1:0]   acc_wdata,
  output logic [DW-1:0]   acc_rdata,
  input  logic [2*DW-1:0] cnt_q,
  input  logic [2*DW-1:0] cmp_q,
  input  logic            flag_q,
  output logic            run,
  output logic [DW-1:0]   temp_q,
  output bmask_t          cnt_we,
  output bmask_t          cmp_we,
  output logic [2*DW-1:0] wval,
  output logic            flag_clr
);
  localparam int CW = 2 * DW;

  logic [DW-1:0] ckstp_q;
  logic wr, rd, wok, hi_wr16, cap_rd16;

  assign wr  = acc_en & acc_wr;
  assign rd  = acc_en & ~acc_wr;
  assign run = ckstp_q[STBY_BIT];
  assign wok = wr & run;

  assign hi_wr16  = wok & mode16 & ((acc_addr == A_CNT_HI) | (acc_addr == A_CMP_HI));
  assign cap_rd16 = rd & mode16 & (acc_addr == A_CNT_HI);

  always_comb begin
    cnt_we   = 2'b00;
    cmp_we   = 2'b00;
    flag_clr = 1'b0;
    wval     = mode16 ? {temp_q, acc_wdata} : {acc_wdata, acc_wdata};
    if (wok) begin
      case (acc_addr)
        A_CNT_HI: cnt_we = mode16 ? 2'b00 : 2'b10;
        A_CNT_LO: cnt_we = mode16 ? 2'b11 : 2'b01;
        A_CMP_HI: cmp_we = mode16 ? 2'b00 : 2'b10;
        A_CMP_LO: cmp_we = mode16 ? 2'b11 : 2'b01;
        A_STAT:   flag_clr = ~acc_wdata[0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        temp_q <= '0;
    else if (hi_wr16)  temp_q <= acc_wdata;
    else if (cap_rd16) temp_q <= cnt_q[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          ckstp_q <= '1;
    else if (wr && acc_addr == A_CKSTP) ckstp_q <= acc_wdata;
  end

  always_comb begin
    acc_rdata = '0;
    if (rd) begin
      case (acc_addr)
        A_CNT_HI: acc_rdata = cnt_q[CW-1:DW];
        A_CNT_LO: acc_rdata = mode16 ? temp_q : cnt_q[DW-1:0];
        A_CMP_HI: acc_rdata = cmp_q[CW-1:DW];
        A_CMP_LO: acc_rdata = cmp_q[DW-1:0];
        A_STAT:   acc_rdata = {{(DW-1){1'b0}}, flag_q};
        A_CKSTP:  acc_rdata = ckstp_q;
        default:  acc_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/tmr16_byte_bridge.sv
module tmr16_byte_bridge
  import tmr16_pkg::*;
#(
  parameter int DW = 8,
  parameter int STBY_BIT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode16,
  input  logic          acc_en,
  input  logic          acc_wr,
  input  logic [2:0]    acc_addr,
  input  logic [DW-1:0] acc_wdata,
  output logic [DW-1:0] acc_rdata,
  input  logic          cnt_tick,
  output logic          match_flag
);
  localparam int CW = 2 * DW;
  localparam logic [CW-1:0] CNT_INIT = '0;
  localparam logic [CW-1:0] CMP_INIT = '1;

  logic [CW-1:0] cnt_q, cmp_q, wval;
  logic [DW-1:0] temp_q;
  bmask_t        cnt_we, cmp_we;
  logic          run, flag_clr;

  tmr16_bus_port #(.DW(DW), .STBY_BIT(STBY_BIT)) u_port (
    .clk(clk), .rst_n(rst_n), .mode16(mode16),
    .acc_en(acc_en), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .cnt_q(cnt_q), .cmp_q(cmp_q), .flag_q(match_flag),
    .run(run), .temp_q(temp_q), .cnt_we(cnt_we), .cmp_we(cmp_we),
    .wval(wval), .flag_clr(flag_clr)
  );

  tmr16_bytereg #(.DW(DW), .NB(2), .INIT(CNT_INIT), .HAS_INC(1'b1)) u_cnt (
    .clk(clk), .rst_n(rst_n), .we(cnt_we), .wval(wval),
    .inc_en(cnt_tick & run), .q(cnt_q)
  );

  tmr16_bytereg #(.DW(DW), .NB(2), .INIT(CMP_INIT), .HAS_INC(1'b0)) u_cmp (
    .clk(clk), .rst_n(rst_n), .we(cmp_we), .wval(wval),
    .inc_en(1'b0), .q(cmp_q)
  );

  tmr16_match_flag #(.CW(CW)) u_match (
    .clk(clk), .rst_n(rst_n), .run(run), .cnt_q(cnt_q), .cmp_q(cmp_q),
    .clr(flag_clr), .flag_q(match_flag)
  );
endmodule

// File: rtl/tmr16_bridge_chk.sv
module tmr16_bridge_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode16,
  input logic          acc_en,
  input logic          acc_wr,
  input logic [2:0]    acc_addr,
  input logic [DW-1:0] acc_wdata,
  input logic          cnt_tick,
  input logic          run,
  input logic [DW-1:0] temp_q,
  input logic [2*DW-1:0] cnt_q,
  input logic [2*DW-1:0] cmp_q,
  input logic          match_flag
);
  localparam int CW = 2 * DW;

  logic wr_run;
  assign wr_run = acc_en && acc_wr && run;

  p_hi_write_latch_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_run && mode16 && acc_addr == 3'd0 && !cnt_tick)
      |=> (cnt_q == $past(cnt_q)) && (temp_q == $past(acc_wdata)));

  p_cnt_lo_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_run && mode16 && acc_addr == 3'd1)
      |=> cnt_q == {$past(temp_q), $past(acc_wdata)});

  p_cmp_lo_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_run && mode16 && acc_addr == 3'd3)
      |=> cmp_q == {$past(temp_q), $past(acc_wdata)});

  p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_tick && !(acc_en && acc_wr && acc_addr[2:1] == 2'b00))
      |=> cnt_q == CW'($past(cnt_q) + CW'(1)));

  p_standby_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt_q) && $stable(cmp_q));

  p_match_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_q == cmp_q) |=> match_flag);

  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (match_flag && !(wr_run && acc_addr == 3'd4 && !acc_wdata[0])) |=> match_flag);
endmodule

bind tmr16_byte_bridge tmr16_bridge_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode16(mode16), .acc_en(acc_en),
  .acc_wr(acc_wr), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
  .cnt_tick(cnt_tick), .run(run), .temp_q(temp_q), .cnt_q(cnt_q),
  .cmp_q(cmp_q), .match_flag(match_flag)
);

// File: tb/tmr16_byte_bridge_tb_top.sv
module tmr16_byte_bridge_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode16 = 1'b0, acc_en = 1'b0, acc_wr = 1'b0, cnt_tick = 1'b0;
  logic [2:0] acc_addr = '0;
  logic [7:0] acc_wdata = '0;
  logic [7:0] acc_rdata;
  logic match_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tmr16_byte_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .mode16(mode16), .acc_en(acc_en),
    .acc_wr(acc_wr), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .cnt_tick(cnt_tick), .match_flag(match_flag)
  );

  // {wr, addr[2:0], data[7:0], mode16, req[3:0]}; data is the expected byte for reads
  localparam int NV = 30;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 3'd0, 8'h00, 1'b1, 4'd1},   // R1 counter high
    {1'b0, 3'd1, 8'h00, 1'b1, 4'd1},   // R1 counter low
    {1'b0, 3'd2, 8'hFF, 1'b0, 4'd1},   // R1 compare high
    {1'b0, 3'd3, 8'hFF, 1'b0, 4'd1},   // R1 compare low
    {1'b0, 3'd4, 8'h00, 1'b0, 4'd1},   // R1 status
    {1'b0, 3'd5, 8'hFF, 1'b0, 4'd1},   // R1 clock-stop
    {1'b1, 3'd0, 8'h12, 1'b1, 4'd2},   // R2 high write to latch
    {1'b0, 3'd0, 8'h00, 1'b0, 4'd2},   // R2 target unchanged
    {1'b0, 3'd1, 8'h00, 1'b0, 4'd2},
    {1'b1, 3'd1, 8'h34, 1'b1, 4'd3},   // R3 commit 0x1234
    {1'b0, 3'd0, 8'h12, 1'b0, 4'd3},
    {1'b0, 3'd1, 8'h34, 1'b0, 4'd3},
    {1'b0, 3'd0, 8'h12, 1'b1, 4'd4},   // R4 16-bit read pair
    {1'b0, 3'd1, 8'h34, 1'b1, 4'd4},
    {1'b1, 3'd1, 8'h56, 1'b0, 4'd6},   // R6 direct low write
    {1'b0, 3'd0, 8'h12, 1'b1, 4'd4},   // R4 capture 0x56
    {1'b1, 3'd1, 8'h99, 1'b0, 4'd6},   // R6 overwrite live low
    {1'b0, 3'd1, 8'h56, 1'b1, 4'd4},   // R4 latched value returned
    {1'b0, 3'd1, 8'h99, 1'b0, 4'd6},   // R6 live low
    {1'b1, 3'd2, 8'hAB, 1'b1, 4'd5},   // R5 compare high to latch
    {1'b1, 3'd1, 8'h01, 1'b1, 4'd5},   // R5 counter low commits 0xAB01
    {1'b0, 3'd0, 8'hAB, 1'b0, 4'd5},
    {1'b0, 3'd1, 8'h01, 1'b0, 4'd5},
    {1'b0, 3'd2, 8'hFF, 1'b0, 4'd5},   // R5 compare untouched
    {1'b1, 3'd3, 8'h22, 1'b0, 4'd6},   // R6 low first
    {1'b1, 3'd2, 8'h11, 1'b0, 4'd6},   // R6 then high
    {1'b0, 3'd3, 8'h22, 1'b0, 4'd6},
    {1'b0, 3'd2, 8'h11, 1'b1, 4'd4},   // R4 compare read direct
    {1'b0, 3'd6, 8'h00, 1'b0, 4'd11},  // R11 unused address
    {1'b0, 3'd7, 8'h00, 1'b0, 4'd11}   // R11 unused address
  };

  task automatic check(input logic [7:0] got, input logic [7:0] exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic acc(input bit wr, input logic [2:0] a, input logic [7:0] d,
                     input bit m, output logic [7:0] rd);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = wr; acc_addr = a; acc_wdata = d; mode16 = m;
    #2 rd = acc_rdata;
    @(posedge clk);
    #1 acc_en = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic rchk(input logic [2:0] a, input bit m, input logic [7:0] exp, input string req);
    logic [7:0] r;
    acc(1'b0, a, 8'h00, m, r);
    check(r, exp, req);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input bit m);
    logic [7:0] r;
    acc(1'b1, a, d, m, r);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    cnt_tick = 1'b1;
    repeat (n) @(negedge clk);
    cnt_tick = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1 check({7'd0, match_flag}, 8'h00, "R1 flag pin");

    for (int i = 0; i < NV; i++) begin
      acc(VEC[i][16], VEC[i][15:13], VEC[i][12:5], VEC[i][4], r);
      if (!VEC[i][16]) check(r, VEC[i][12:5], $sformatf("R%0d vec %0d", VEC[i][3:0], i));
    end

    // R7 / R9: counting to a match
    wr(3'd2, 8'h11, 1'b1); wr(3'd3, 8'h05, 1'b1);
    wr(3'd0, 8'h11, 1'b1); wr(3'd1, 8'h00, 1'b1);
    ticks(4);
    @(negedge clk);
    check({7'd0, match_flag}, 8'h00, "R9 no early match");
    rchk(3'd1, 1'b0, 8'h04, "R7 four ticks");
    ticks(1);
    check({7'd0, match_flag}, 8'h00, "R9 one-edge latency");
    @(negedge clk);
    check({7'd0, match_flag}, 8'h01, "R9 flag set");
    rchk(3'd4, 1'b0, 8'h01, "R9 status bit");

    // R7: write wins over increment on the same edge
    @(negedge clk); cnt_tick = 1'b1;
    wr(3'd1, 8'h40, 1'b0);
    cnt_tick = 1'b0;
    rchk(3'd1, 1'b0, 8'h40, "R7 write priority");

    // R10: sticky, write-1 ignored, write-0 clears
    wr(3'd4, 8'h01, 1'b0);
    check({7'd0, match_flag}, 8'h01, "R10 write one ignored");
    wr(3'd4, 8'h00, 1'b0);
    check({7'd0, match_flag}, 8'h00, "R10 clear");
    wr(3'd1, 8'h05, 1'b0);
    wr(3'd4, 8'h00, 1'b0);
    check({7'd0, match_flag}, 8'h01, "R10 set wins over clear");
    wr(3'd1, 8'h00, 1'b0);
    wr(3'd4, 8'h00, 1'b0);
    check({7'd0, match_flag}, 8'h00, "R10 clear after move");

    // R8: standby
    wr(3'd5, 8'hFB, 1'b0);
    rchk(3'd5, 1'b0, 8'hFB, "R8 clock-stop readback");
    ticks(10);
    rchk(3'd1, 1'b0, 8'h00, "R8 counter frozen");
    wr(3'd1, 8'h77, 1'b0);
    rchk(3'd1, 1'b0, 8'h00, "R8 counter write ignored");
    wr(3'd2, 8'h99, 1'b1); wr(3'd3, 8'h88, 1'b1);
    rchk(3'd2, 1'b0, 8'h11, "R8 compare high held");
    rchk(3'd3, 1'b0, 8'h05, "R8 compare low held");
    wr(3'd5, 8'hFF, 1'b0);
    ticks(3);
    rchk(3'd1, 1'b0, 8'h03, "R8 counting after release");
    check({7'd0, match_flag}, 8'h00, "R9 no match below compare");

    // R1: reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rchk(3'd0, 1'b0, 8'h00, "R1 counter after reset");
    rchk(3'd3, 1'b0, 8'hFF, "R1 compare after reset");
    check({7'd0, match_flag}, 8'h00, "R1 flag after reset");
    #2 check(acc_rdata, 8'h00, "R11 idle read data");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule